// File: doc/BRIEF.md
# Vector Loop Issue Sequencer

This block sits between instruction decode and execute. It turns ordinary scalar operations into short vector loops. Software programs a single packed state register that holds a maximum length, a current length, a source offset, a destination offset and a grouping value. Every write to that register is clamped, so the stored fields always form a consistent configuration. A per-register tag vector marks which architectural registers are vectorised. No new opcodes exist: the sequencer treats the opcode payload as opaque and copies it unchanged.

A decoded instruction is accepted over a valid/ready handshake and held inside the block. If none of its three register operands is tagged, it leaves as exactly one operation with its register numbers untouched. If any operand is tagged, the block holds decode-ready low and issues one operation per element.

- Tagged sources step upward from base plus source offset.
- The tagged destination steps upward from base plus destination offset.
- Untagged operands stay fixed for every element.

Both offsets in the state register track the element being issued, so an interrupted loop can be saved and resumed. They return to zero when the loop finishes.

Back-pressure rules:
- The output interface holds every field stable while `out_valid` is high and `out_ready` is low.
- Only a handshake advances the loop.
- The input interface takes a new instruction only when `in_ready` is high.
- `in_ready` stays low from acceptance until the cycle after the final output handshake.

Top module: `vec_issue_seq`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `csr_rdata` reads 0.
- R2: The state register layout is: bits 5:0 hold the maximum length minus one, bits 11:6 the length minus one, bits 17:12 the source offset, bits 23:18 the destination offset, bits 26:24 the grouping value. Bits 31:27 read as 0 whatever is written.
- R3: A write clamps the stored maximum length minus one to at most MAX_LEN-1.
- R4: A write clamps the stored length minus one to at most the clamped maximum length minus one.
- R5: A write clamps each offset to at most the clamped length minus one.
- R6: An instruction with no tagged operand produces exactly one operation with `out_last`=1, the same opcode and register numbers, and leaves both offsets unchanged.
- R7: An instruction with a tagged operand produces operations numbered e = 0, 1, ..., n-1, where n = length - max(src offset, dst offset). For element e:
  - a tagged `rd` is base + dst offset + e;
  - a tagged `rs1`/`rs2` is base + src offset + e;
  - untagged operands and the opcode are unchanged;
  - `out_last` is 1 only on the final element.
- R8: Register numbers computed by R7 wrap modulo 2^REG_W.
- R9: `in_ready` is 0 from the accepting edge until the final output handshake, and is 1 (with `out_valid` 0) in the cycle after it.
- R10: While `out_valid` is 1 and `out_ready` is 0, all output fields stay stable and the loop does not advance.
- R11: During a vector loop, the offset fields of `csr_rdata` read src offset + e and dst offset + e for the element on the output. After the final handshake both read 0.
- R12: A state register write while an instruction is held (`out_valid`=1) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | State register write strobe |
| csr_wdata | input | 32 | State register write data |
| csr_rdata | output | 32 | State register read data (clamped fields) |
| tag | input | 2^REG_W | Per-register vectorised tag bits |
| in_valid | input | 1 | Decoded instruction valid |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_op | input | OP_W | Opaque opcode payload |
| in_rd | input | REG_W | Destination register number |
| in_rs1 | input | REG_W | First source register number |
| in_rs2 | input | REG_W | Second source register number |
| out_valid | output | 1 | Issued operation valid |
| out_ready | input | 1 | Execute stage accepts the operation |
| out_op | output | OP_W | Opcode payload, unchanged |
| out_rd | output | REG_W | Destination register for this element |
| out_rs1 | output | REG_W | First source register for this element |
| out_rs2 | output | REG_W | Second source register for this element |
| out_last | output | 1 | Final operation of the instruction |

## Verification
The bench builds the sequencer with MAX_LEN=8 and REG_W=5, so the maximum-length clamp actually bites.

The clamp logic is swept over all 4096 combinations of the two length fields, with varying offsets, grouping value and reserved bits. Expected values are computed arithmetically.

Issue behaviour is checked for:
- every length from 1 to 8;
- all eight operand tag patterns;
- zero and non-zero starting offsets;
- base registers near 31, which force the wrap.

Each element sees its own pattern of output stalls. One case also attempts a state write in the middle of a loop.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int LEN_W = 6;
  localparam int SUB_W = 3;
  localparam int CSR_W = 32;

  typedef struct packed {
    logic [SUB_W-1:0] grp;
    logic [LEN_W-1:0] dst_off;
    logic [LEN_W-1:0] src_off;
    logic [LEN_W-1:0] len_m1;
    logic [LEN_W-1:0] max_m1;
  } vstate_t;

  localparam int ST_W = $bits(vstate_t);

  function automatic logic [LEN_W-1:0] umin(input logic [LEN_W-1:0] a,
                                            input logic [LEN_W-1:0] b);
    return (a > b) ? b : a;
  endfunction

  function automatic vstate_t clamp_write(input logic [CSR_W-1:0] d,
                                          input logic [LEN_W-1:0] lim_m1);
    vstate_t s;
    s.max_m1  = umin(d[5:0], lim_m1);
    s.len_m1  = umin(d[11:6], s.max_m1);
    s.src_off = umin(d[17:12], s.len_m1);
    s.dst_off = umin(d[23:18], s.len_m1);
    s.grp     = d[26:24];
    return s;
  endfunction
endpackage

// File: rtl/vis_tag_lookup.sv
module vis_tag_lookup #(
  parameter int REG_W = 5,
  parameter int NOPS  = 3
) (
  input  logic [(1<<REG_W)-1:0]        tag,
  input  logic [NOPS-1:0][REG_W-1:0]   regs,
  output logic [NOPS-1:0]              hit
);
  for (genvar i = 0; i < NOPS; i++) begin : g_op
    assign hit[i] = tag[regs[i]];
  end
endmodule

// File: rtl/vis_state_reg.sv
module vis_state_reg
  import vis_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             busy,
  input  logic             step,
  input  logic             done,
  output vstate_t          st,
  output logic [CSR_W-1:0] rdata
);
  localparam logic [LEN_W-1:0] LIM_M1 = LEN_W'(MAX_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (wr_en && !busy) begin
      st <= clamp_write(wr_data, LIM_M1);
    end else if (done) begin
      st.src_off <= '0;
      st.dst_off <= '0;
    end else if (step) begin
      st.src_off <= st.src_off + 1'b1;
      st.dst_off <= st.dst_off + 1'b1;
    end
  end

  assign rdata = CSR_W'(st);

  // R3
  max_le_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.max_m1 <= LIM_M1);
  // R4
  len_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.len_m1 <= st.max_m1);
  // R5
  offs_le_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.src_off <= st.len_m1) && (st.dst_off <= st.len_m1));
  // R12
  busy_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !step && !done) |=> $stable(st));
  // R11
  offs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (st.src_off == '0) && (st.dst_off == '0));
endmodule

// File: rtl/vis_issue_ctrl.sv
module vis_issue_ctrl
  import vis_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int OP_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OP_W-1:0]      in_op,
  input  logic [2:0][REG_W-1:0] in_regs,
  input  logic [2:0]           in_hit,
  input  logic [LEN_W-1:0]     len_m1,
  input  logic [LEN_W-1:0]     src_off,
  input  logic [LEN_W-1:0]     dst_off,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OP_W-1:0]      out_op,
  output logic [2:0][REG_W-1:0] out_regs,
  output logic                 out_last,
  output logic                 step,
  output logic                 done
);
  logic                  busy;
  logic [OP_W-1:0]       op_q;
  logic [2:0][REG_W-1:0] reg_q;
  logic [2:0]            hit_q;
  logic                  vec, accept, fire;

  assign vec      = |hit_q;
  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign fire     = busy && out_ready;
  assign out_last = !vec || (src_off == len_m1) || (dst_off == len_m1);
  assign step     = fire && vec && !out_last;
  assign done     = fire && vec && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      op_q  <= '0;
      reg_q <= '0;
      hit_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      op_q  <= in_op;
      reg_q <= in_regs;
      hit_q <= in_hit;
    end else if (fire && out_last) begin
      busy <= 1'b0;
    end
  end

  assign out_valid = busy;
  assign out_op    = op_q;

  // operand 0 is the destination, 1 and 2 are sources
  for (genvar i = 0; i < 3; i++) begin : g_reg
    logic [REG_W-1:0] offs;
    if (i == 0) begin : g_dst
      assign offs = REG_W'(dst_off);
    end else begin : g_src
      assign offs = REG_W'(src_off);
    end
    assign out_regs[i] = hit_q[i] ? reg_q[i] + offs : reg_q[i];
  end

  // R9
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> (in_ready && !out_valid));
  // R9
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!in_ready && out_valid));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_regs) &&
                                   $stable(out_op) && $stable(out_last)));
  // R6
  scalar_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_hit == '0)) |=> (out_last && out_regs == $past(in_regs)));
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
  import vis_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int REG_W   = 5,
  parameter int OP_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_we,
  input  logic [31:0]           csr_wdata,
  output logic [31:0]           csr_rdata,
  input  logic [(1<<REG_W)-1:0] tag,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OP_W-1:0]       in_op,
  input  logic [REG_W-1:0]      in_rd,
  input  logic [REG_W-1:0]      in_rs1,
  input  logic [REG_W-1:0]      in_rs2,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OP_W-1:0]       out_op,
  output logic [REG_W-1:0]      out_rd,
  output logic [REG_W-1:0]      out_rs1,
  output logic [REG_W-1:0]      out_rs2,
  output logic                  out_last
);
  localparam int NOPS = 3;

  vstate_t                    st;
  logic [NOPS-1:0][REG_W-1:0] in_regs, out_regs;
  logic [NOPS-1:0]            hit;
  logic                       step, done;

  assign in_regs = {in_rs2, in_rs1, in_rd};

  vis_tag_lookup #(.REG_W(REG_W), .NOPS(NOPS)) u_tag (
    .tag  (tag),
    .regs (in_regs),
    .hit  (hit)
  );

  vis_state_reg #(.MAX_LEN(MAX_LEN)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (csr_we),
    .wr_data (csr_wdata),
    .busy    (out_valid),
    .step    (step),
    .done    (done),
    .st      (st),
    .rdata   (csr_rdata)
  );

  vis_issue_ctrl #(.REG_W(REG_W), .OP_W(OP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_regs   (in_regs),
    .in_hit    (hit),
    .len_m1    (st.len_m1),
    .src_off   (st.src_off),
    .dst_off   (st.dst_off),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_op    (out_op),
    .out_regs  (out_regs),
    .out_last  (out_last),
    .step      (step),
    .done      (done)
  );

  assign out_rd  = out_regs[0];
  assign out_rs1 = out_regs[1];
  assign out_rs2 = out_regs[2];
endmodule

// File: tb/sim_vec_issue_seq.sv
`timescale 1ns/1ps
module sim_vec_issue_seq;
  localparam int ML = 8;
  localparam int RW = 5;
  localparam int OW = 32;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic [31:0] tag = 0;
  logic in_valid = 0, in_ready;
  logic [OW-1:0] in_op = 0, out_op;
  logic [RW-1:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0, out_rd, out_rs1, out_rs2;
  logic out_valid, out_ready = 0, out_last;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  vec_issue_seq #(.MAX_LEN(ML), .REG_W(RW), .OP_W(OW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(int g, int d, int s, int l, int m);
    return (32'(g) << 24) | (32'(d) << 18) | (32'(s) << 12) | (32'(l) << 6) | 32'(m);
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic csr_write(input logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  // length vl, offsets s/d, tag mask bit0 rd, bit1 rs1, bit2 rs2
  task automatic run_instr(int rd, int rs1, int rs2, int tm, int vl, int s, int d, bit wr_busy);
    int n, st;
    bit td, t1, t2, vec;
    logic [31:0] op;
    op = 32'h1000_0000 + 32'(rd * 1024 + rs1 * 32 + rs2 + tm * 7);
    tag = 0;
    if (tm[0]) tag[rd] = 1;
    if (tm[1]) tag[rs1] = 1;
    if (tm[2]) tag[rs2] = 1;
    td = tag[rd]; t1 = tag[rs1]; t2 = tag[rs2];
    vec = td | t1 | t2;
    n = vec ? vl - ((s > d) ? s : d) : 1;
    check("R9 ready idle", 32'(in_ready), 1);
    in_valid = 1; in_op = op; in_rd = RW'(rd); in_rs1 = RW'(rs1); in_rs2 = RW'(rs2);
    @(negedge clk); in_valid = 0;
    for (int e = 0; e < n; e++) begin
      int es, ed;
      es = vec ? s + e : s;
      ed = vec ? d + e : d;
      st = (e + rd + tm) % 3;
      if (wr_busy && e == 0 && st == 0) st = 1;
      for (int k = 0; k < st; k++) begin
        if (wr_busy && e == 0 && k == 0) begin
          csr_we = 1; csr_wdata = 32'h0000_0000;
        end
        check("R10 hold rd", 32'(out_rd), td ? 32'((rd + d + e) % 32) : 32'(rd));
        check("R10 hold valid", 32'(out_valid), 1);
        @(negedge clk); csr_we = 0;
      end
      check("R7 op", out_op, op);
      check(td ? "R8 R7 rd" : "R6 rd", 32'(out_rd), td ? 32'((rd + d + e) % 32) : 32'(rd));
      check(t1 ? "R8 R7 rs1" : "R6 rs1", 32'(out_rs1), t1 ? 32'((rs1 + s + e) % 32) : 32'(rs1));
      check(t2 ? "R8 R7 rs2" : "R6 rs2", 32'(out_rs2), t2 ? 32'((rs2 + s + e) % 32) : 32'(rs2));
      check("R7 last", 32'(out_last), 32'(e == n - 1));
      check("R9 stall", 32'(in_ready), 0);
      check(wr_busy ? "R12 drop write" : "R11 offsets", csr_rdata, pack(2, ed, es, vl - 1, ML - 1));
      out_ready = 1;
      @(negedge clk); out_ready = 0;
    end
    check("R9 ready back", 32'(in_ready), 1);
    check("R9 valid low", 32'(out_valid), 0);
    check(vec ? "R11 offs clear" : "R6 offs kept", csr_rdata,
          vec ? pack(2, 0, 0, vl - 1, ML - 1) : pack(2, d, s, vl - 1, ML - 1));
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    check("R1 in_ready", 32'(in_ready), 1);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 rdata", csr_rdata, 0);
    // R2 layout
    csr_write(pack(5, 1, 2, 3, 5));
    check("R2 layout", csr_rdata, pack(5, 1, 2, 3, 5));
    // R2-R5 sweep
    for (int m = 0; m < 64; m++) begin
      for (int v = 0; v < 64; v++) begin
        int sf, df, g, em, ev;
        sf = (m * 7 + v * 3) % 64;
        df = (m * 5 + v * 11) % 64;
        g  = (m + v) % 8;
        em = imin(m, ML - 1);
        ev = imin(v, em);
        csr_write(32'hF800_0000 | pack(g, df, sf, v, m));
        check("R3 R4 R5 R2 clamp", csr_rdata,
              pack(g, imin(df, ev), imin(sf, ev), ev, em));
      end
    end
    // R6-R11 issue sweep
    for (int vl = 1; vl <= ML; vl++) begin
      for (int oc = 0; oc < 2; oc++) begin
        int s, d;
        s = oc ? imin(1, vl - 1) : 0;
        d = oc ? imin(2, vl - 1) : 0;
        for (int tm = 0; tm < 8; tm++) begin
          csr_write(pack(2, d, s, vl - 1, ML - 1));
          run_instr(3, 10, 20, tm, vl, s, d, 0);
          csr_write(pack(2, d, s, vl - 1, ML - 1));
          run_instr(31, 30, 29, tm, vl, s, d, 0);
        end
      end
    end
    // R12 write during loop
    csr_write(pack(2, 0, 0, 5, ML - 1));
    run_instr(7, 8, 9, 3, 6, 0, 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule